// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

This block is an 8-bit binary down-counter for a low-power timekeeping subsystem. Its clock is the system clock. A one-cycle enable pulse, `ref_tick`, marks each period of a 32.768 kHz reference. A free-running prescaler divides the reference into four tick rates: 4096 Hz, 64 Hz, 1 Hz, and one tick per minute. The per-minute tick comes from counting sixty of the 1 Hz ticks. The host picks one of these rates, loads a start value, and enables the timer. The counter then moves down by one on each selected tick.

When the count reaches its last step, the counter reloads the value the host last wrote and keeps running. At the same step it sets a sticky expiry flag, which only a host write can clear. An interrupt output is gated by an enable bit. It shows either the flag as a level or a pulse that lasts one tick of the selected rate after each expiry. The host sees three byte registers through a simple write strobe and a combinational read mux. The bus protocol and the pad drivers sit outside this block.

Top module: `tick_countdown_timer`

## Requirements
- R1: After reset the control register (address 1) reads 0x03, the count register (address 2) reads 0x00, the status register (address 0) reads 0x00 and `irq` is low.
- R2: Control bits [1:0] select the tick. Value 0 gives one tick per 2^FAST_LOG2 reference pulses and value 1 gives one per 2^MID_LOG2. Value 2 gives one per 2^PRESC_W and value 3 gives one per MIN_DIV×2^PRESC_W. The defaults produce 4096 Hz, 64 Hz, 1 Hz and 1/60 Hz from 32.768 kHz. Tick phase is counted from reset.
- R3: While control bit 7 (enable) is 0, the count does not change on ticks.
- R4: A write to address 2 sets both the live count and the reload value. A read of address 2 returns the live count, which falls by one on each selected tick while enabled.
- R5: A tick taken while the count is 1 reloads the count from the reload value and sets the flag (status bit 0).
- R6: With a count of 0, ticks leave the count at 0 and never set the flag.
- R7: The flag is sticky. A status write with bit 0 = 0 clears it and bit 0 = 1 leaves it as it is. An expiry in the same cycle as a clear leaves it set.
- R8: Status bit 1 enables the interrupt. While it is 0, `irq` stays low.
- R9: With status bit 2 = 0 (level mode), `irq` equals the flag whenever the interrupt is enabled.
- R10: With status bit 2 = 1 (pulse mode), `irq` rises in the cycle after an expiry and falls after the next selected tick that is not an expiry, whatever the state of the flag.
- R11: The per-minute tick falls on every MIN_DIV-th slow tick, and the prescaler runs whether or not the timer is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address for read and write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| irq | output | 1 | Timer interrupt |

## Verification
A fault in the prescaler phase or the minute divider shows up as a wrong count the first time a tick boundary is crossed. With small bench dividers this happens within tens of reference pulses, or within one minute period for the slowest source. A wrong reload or expiry decision shows up in the first countdown period, because the count then differs from its reload value and the flag comes up early or late. A fault in the interrupt mode logic or the flag clear logic shows on `irq` and on the status read within one selected tick of the expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_W = 8;
  typedef logic [TMR_W-1:0] tcount_t;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_MID  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_MIN  = 2'd3
  } src_sel_e;

  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  // Count of 1 is the final step of a period.
  function automatic logic cd_expires(input tcount_t cnt);
    return cnt == tcount_t'(1);
  endfunction

  // Next count after one tick: zero parks, final step reloads.
  function automatic tcount_t cd_next(input tcount_t cnt, input tcount_t rld);
    if (cnt == '0) return '0;
    if (cd_expires(cnt)) return rld;
    return cnt - tcount_t'(1);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRESC_W   = 15,
  parameter int unsigned FAST_LOG2 = 3,
  parameter int unsigned MID_LOG2  = 9,
  parameter int unsigned MIN_DIV   = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  output logic tick_fast,
  output logic tick_mid,
  output logic tick_slow,
  output logic tick_min
);
  localparam int unsigned SEC_W = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(MIN_DIV - 1);

  logic [PRESC_W-1:0] pre_q;
  logic [SEC_W-1:0]   sec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else if (ref_tick) pre_q <= pre_q + 1'b1;
  end

  // A tap fires on the reference pulse that wraps its low bits.
  assign tick_fast = ref_tick && (&pre_q[FAST_LOG2-1:0]);
  assign tick_mid  = ref_tick && (&pre_q[MID_LOG2-1:0]);
  assign tick_slow = ref_tick && (&pre_q);

  always_ff @(posedge clk) begin
    if (!rst_n) sec_q <= '0;
    else if (tick_slow) sec_q <= (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
  end

  assign tick_min = tick_slow && (sec_q == SEC_LAST);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    en,
  input  logic    load_wr,
  input  tcount_t load_val,
  output tcount_t cnt,
  output tcount_t rld,
  output logic    expire_evt
);
  tcount_t cnt_q, rld_q;

  assign expire_evt = tick && en && !load_wr && cd_expires(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else if (load_wr) begin
      cnt_q <= load_val;
      rld_q <= load_val;
    end else if (tick && en) begin
      cnt_q <= cd_next(cnt_q, rld_q);
    end
  end

  assign cnt = cnt_q;
  assign rld = rld_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic expire_evt,
  input  logic flag_clr_req,
  input  logic irq_en,
  input  logic pulse_mode,
  output logic flag,
  output logic pulse_active,
  output logic irq
);
  logic flag_q, pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (expire_evt) flag_q <= 1'b1;
    else if (flag_clr_req) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else if (expire_evt) pulse_q <= 1'b1;
    else if (tick) pulse_q <= 1'b0;
  end

  assign flag         = flag_q;
  assign pulse_active = pulse_q;
  assign irq          = irq_en && (pulse_mode ? pulse_q : flag_q);
endmodule

// File: rtl/tick_countdown_timer.sv
module tick_countdown_timer
  import tmr_pkg::*;
#(
  parameter int unsigned PRESC_W   = 15,
  parameter int unsigned FAST_LOG2 = 3,
  parameter int unsigned MID_LOG2  = 9,
  parameter int unsigned MIN_DIV   = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       host_wr,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq
);
  logic     tick_fast, tick_mid, tick_slow, tick_min, tick_sel;
  logic     en_q, irq_en_q, pulse_mode_q;
  src_sel_e sel_q;
  logic     stat_wr, ctrl_wr, cnt_wr, flag_clr_req;
  logic     expire_evt, flag_q, pulse_active;
  tcount_t  cnt_q, rld_q;

  tmr_prescaler #(
    .PRESC_W(PRESC_W), .FAST_LOG2(FAST_LOG2),
    .MID_LOG2(MID_LOG2), .MIN_DIV(MIN_DIV)
  ) presc_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .tick_fast(tick_fast), .tick_mid(tick_mid),
    .tick_slow(tick_slow), .tick_min(tick_min)
  );

  always_comb begin
    case (sel_q)
      SRC_FAST: tick_sel = tick_fast;
      SRC_MID:  tick_sel = tick_mid;
      SRC_SLOW: tick_sel = tick_slow;
      default:  tick_sel = tick_min;
    endcase
  end

  assign stat_wr      = host_wr && (host_addr == ADDR_STAT);
  assign ctrl_wr      = host_wr && (host_addr == ADDR_CTRL);
  assign cnt_wr       = host_wr && (host_addr == ADDR_CNT);
  assign flag_clr_req = stat_wr && !host_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q         <= 1'b0;
      sel_q        <= SRC_MIN;
      irq_en_q     <= 1'b0;
      pulse_mode_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= host_wdata[7];
        sel_q <= src_sel_e'(host_wdata[1:0]);
      end
      if (stat_wr) begin
        irq_en_q     <= host_wdata[1];
        pulse_mode_q <= host_wdata[2];
      end
    end
  end

  tmr_core core_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_sel), .en(en_q),
    .load_wr(cnt_wr), .load_val(host_wdata),
    .cnt(cnt_q), .rld(rld_q), .expire_evt(expire_evt)
  );

  tmr_irq irq_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_sel), .expire_evt(expire_evt),
    .flag_clr_req(flag_clr_req), .irq_en(irq_en_q), .pulse_mode(pulse_mode_q),
    .flag(flag_q), .pulse_active(pulse_active), .irq(irq)
  );

  always_comb begin
    case (host_addr)
      ADDR_STAT: host_rdata = {5'b0, pulse_mode_q, irq_en_q, flag_q};
      ADDR_CTRL: host_rdata = {en_q, 5'b0, sel_q};
      ADDR_CNT:  host_rdata = cnt_q;
      default:   host_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/tick_countdown_timer_chk.sv
module tick_countdown_timer_chk
  import tmr_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    expire_evt,
  input logic    flag_q,
  input logic    flag_clr_req,
  input logic    en_q,
  input logic    cnt_wr,
  input tcount_t cnt_q,
  input tcount_t rld_q,
  input logic    irq_en_q,
  input logic    pulse_mode_q,
  input logic    irq
);
  assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_wr) |=> $stable(cnt_q));

  assert_reload_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (cnt_q == $past(rld_q)) && flag_q);

  assert_zero_never_expires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !expire_evt);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr_req) |=> flag_q);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q |-> !irq);

  assert_pulse_after_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && $past(irq_en_q) && irq_en_q && pulse_mode_q && $stable(pulse_mode_q))
      |=> (irq || !irq_en_q || !pulse_mode_q));
endmodule

bind tick_countdown_timer tick_countdown_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .expire_evt(expire_evt), .flag_q(flag_q),
  .flag_clr_req(flag_clr_req), .en_q(en_q), .cnt_wr(cnt_wr),
  .cnt_q(cnt_q), .rld_q(rld_q), .irq_en_q(irq_en_q),
  .pulse_mode_q(pulse_mode_q), .irq(irq)
);

// File: tb/tick_countdown_timer_tb_top.sv
`timescale 1ns/1ps
module tick_countdown_timer_tb_top;
  // Small dividers: fast /8, mid /64, slow /256, minute /15360 reference pulses.
  localparam int unsigned PW = 8, FL = 3, ML = 6, MD = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_countdown_timer #(.PRESC_W(PW), .FAST_LOG2(FL), .MID_LOG2(ML), .MIN_DIV(MD)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [7:0]  load;
    logic [15:0] pulses;
    logic [7:0]  exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    {2'd0, 8'd5, 16'd24,    8'd2, 1'b0},
    {2'd0, 8'd5, 16'd40,    8'd5, 1'b1},
    {2'd0, 8'd3, 16'd64,    8'd1, 1'b1},
    {2'd1, 8'd2, 16'd128,   8'd2, 1'b1},
    {2'd1, 8'd4, 16'd191,   8'd2, 1'b0},
    {2'd2, 8'd3, 16'd512,   8'd1, 1'b0},
    {2'd0, 8'd0, 16'd80,    8'd0, 1'b0},
    {2'd3, 8'd1, 16'd15360, 8'd1, 1'b1},
    {2'd3, 8'd2, 16'd15359, 8'd2, 1'b0},
    {2'd2, 8'd1, 16'd256,   8'd1, 1'b1}
  };

  function automatic string vec_tag(input int i);
    case (i)
      6:       return "R6 zero load";
      7, 8:    return "R11 minute source";
      3, 4, 5: return "R2 source rate";
      default: return "R4 R5 countdown";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ref_tick = 1'b0;
    host_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic pulse(input int n);
    if (n > 0) begin
      @(negedge clk);
      ref_tick = 1'b1;
      repeat (n) @(negedge clk);
      ref_tick = 1'b0;
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    // R1 reset state
    do_reset();
    rd(2'd1, d); check("R1 control reset", d, 8'h03);
    rd(2'd2, d); check("R1 count reset", d, 0);
    rd(2'd0, d); check("R1 status reset", d, 0);
    check("R1 irq reset", irq, 0);

    // Vector table: each row from reset so tick phase is known.
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(2'd1, {1'b1, 5'b0, VEC[i].sel});
      wr(2'd2, VEC[i].load);
      pulse(int'(VEC[i].pulses));
      rd(2'd2, d); check({vec_tag(i), " count"}, d, VEC[i].exp_cnt);
      rd(2'd0, d); check({vec_tag(i), " flag"}, d[0], VEC[i].exp_flag);
    end

    // R3: disabled timer holds its count.
    do_reset();
    wr(2'd1, 8'h00);
    wr(2'd2, 8'd5);
    pulse(40);
    rd(2'd2, d); check("R3 disabled hold", d, 5);
    rd(2'd0, d); check("R3 disabled no flag", d[0], 0);

    // R10 pulse mode, then R9/R8/R7 level mode and clear behaviour.
    do_reset();
    wr(2'd0, 8'h06);
    wr(2'd1, 8'h80);
    wr(2'd2, 8'd2);
    pulse(15);
    check("R10 no pulse before expiry", irq, 0);
    pulse(1);
    check("R10 pulse after expiry", irq, 1);
    pulse(8);
    check("R10 pulse ends after next tick", irq, 0);
    rd(2'd0, d); check("R10 flag still set", d[0], 1);
    wr(2'd0, 8'h03);
    check("R9 level irq follows flag", irq, 1);
    rd(2'd0, d); check("R7 write one keeps flag", d[0], 1);
    wr(2'd0, 8'h01);
    check("R8 irq masked", irq, 0);
    rd(2'd0, d); check("R8 flag kept while masked", d[0], 1);
    wr(2'd0, 8'h02);
    rd(2'd0, d); check("R7 write zero clears flag", d[0], 0);
    check("R9 level irq low after clear", irq, 0);

    // R7: expiry in the same cycle as a clear keeps the flag.
    do_reset();
    wr(2'd1, 8'h80);
    wr(2'd2, 8'd1);
    pulse(7);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'h00; ref_tick = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; ref_tick = 1'b0;
    rd(2'd0, d); check("R7 set wins over clear", d[0], 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule